// File: doc/BRIEF.md
# I2C Slave Address Recogniser

This block watches a two-wire serial bus and decides whether the first byte after a START condition is addressed to it. It keeps two software-visible settings: a 7-bit own address with a general-call enable bit, and a 7-bit don't-care mask. After a START, it shifts in eight bits on rising SCL edges, most significant bit first. The top seven bits are the address and the last bit is the read/write direction. The address is compared against the programmed one, and any bit position whose mask bit is set is skipped. The all-zero general-call address is also accepted when its enable bit is set.

On a hit, the block asks the pad logic to pull SDA low for the acknowledge clock. It also sets a sticky interrupt flag and records the direction bit. On a miss, it leaves SDA alone and ignores the rest of the transfer until a new START arrives. A STOP sends it back to idle. SCL and SDA are resynchronised into the system clock domain before any edge is detected. The settings and the flag sit behind a small byte-wide register port with a combinational read path. Select 0 is the own-address register, select 1 is the mask register, and select 2 is the status register.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, the own-address register reads 0xFE, the mask register reads 0x00, the status register reads 0x00, and sdaPullLow, irq and rwBit are all 0.
- R2: Bit 0 of the mask register (select 1) always reads 0, and writes to it have no effect. Bits 7:1 hold the mask.
- R3: The first byte after a START is sampled MSB first on rising SCL edges. Its bits 7:1 are the received address. The address matches when every unmasked bit equals bits 7:1 of the own-address register (select 0).
- R4: A 1 in mask bit k+1 makes the compare ignore received address bit k.
- R5: A received address of 0x00 always matches when own-address bit 0 (general-call enable) is 1. When that bit is 0, address 0x00 matches only through the normal compare of R3 and R4.
- R6: On a match, sdaPullLow is 1 from the falling SCL edge after the eighth bit until the falling SCL edge after the ninth bit. Otherwise it is 0.
- R7: A match sets irq, which is status bit 0 (select 2). Writing 1 to status bit 0 clears irq. Writing 0 has no effect, and irq stays set otherwise.
- R8: On a match, the eighth received bit (read/write) is latched. It appears on rwBit and as status bit 1, and it is held until the next match.
- R9: After a mismatching address, the block neither drives SDA nor flags an interrupt for the rest of the transfer, even if later bytes carry the matching address.
- R10: A repeated START restarts address capture from the first bit. A STOP returns the block to idle, so bits clocked after a STOP without a new START are not treated as an address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock from the bus, asynchronous |
| sdaIn | input | 1 | Serial data from the bus, asynchronous |
| regSel | input | 2 | Register select: 0 own address, 1 mask, 2 status |
| regWr | input | 1 | Write strobe for the selected register |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data of the selected register (combinational) |
| sdaPullLow | output | 1 | Request to drive SDA low (acknowledge) |
| irq | output | 1 | Sticky address-match interrupt flag |
| rwBit | output | 1 | Direction bit of the last matched address |

## Verification
The bench sweeps all 128 received addresses under three configurations: a plain compare, a masked compare with general call enabled, and the reset setting. Every outcome is checked against the match formula computed in the bench. A design that reversed the mask polarity or ignored the general-call enable would acknowledge the wrong subset of addresses. A mis-counted bit index would open the acknowledge window one clock early or late, and this shows up in the samples taken before, during and after the ninth clock. Separate cases cover the remaining behaviours. A repeated START in mid-address must restart capture, so a design that kept the stale bits would refuse the valid address. Bits clocked after a STOP must be ignored. A data byte that carries the own address after a refused address must be ignored, so a design that re-armed on any byte would acknowledge it falsely. Writes of 0 and 1 to the interrupt flag must leave it set and clear it respectively.

// File: rtl/i2c_addr_match_pkg.sv
package i2c_addr_match_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam logic [1:0] SEL_OWN    = 2'd0;
  localparam logic [1:0] SEL_MASK   = 2'd1;
  localparam logic [1:0] SEL_STATUS = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_ACK, ST_SKIP} ctlState_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } busEvt_t;

  typedef struct packed {
    logic clrShift;
    logic shiftEn;
    logic hitStrobe;
  } ctlStrobe_t;
endpackage

// File: rtl/i2c_addr_match_dp.sv
module i2c_addr_match_dp
  import i2c_addr_match_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] OWN_RESET = 8'hFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  ctlStrobe_t        strobe,
  output busEvt_t           evt,
  output logic              addrHit,
  output logic              irq,
  output logic              rwBit
);
  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [SYNC_TOP:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic [BYTE_W-1:0] shiftReg;
  logic [ADDR_W-1:0] ownAddr, maskBits, rxAddr;
  logic gcEnable, irqFlag, rwReg;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_TOP-1:0], sclIn};
          sdaSync <= {sdaSync[SYNC_TOP-1:0], sdaIn};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_TOP];
  assign sdaS = sdaSync[SYNC_TOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_comb begin
    evt.sclRise   = sclS & ~sclD;
    evt.sclFall   = ~sclS & sclD;
    evt.startSeen = sclS & sclD & sdaD & ~sdaS;
    evt.stopSeen  = sclS & sclD & ~sdaD & sdaS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.clrShift) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
  end

  assign rxAddr  = shiftReg[BYTE_W-1:1];
  assign addrHit = (((rxAddr ^ ownAddr) & ~maskBits) == '0) ||
                   (gcEnable && (rxAddr == '0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownAddr  <= OWN_RESET[BYTE_W-1:1];
      gcEnable <= OWN_RESET[0];
      maskBits <= '0;
    end else if (regWr) begin
      if (regSel == SEL_OWN) begin
        ownAddr  <= regWdata[BYTE_W-1:1];
        gcEnable <= regWdata[0];
      end else if (regSel == SEL_MASK) begin
        maskBits <= regWdata[BYTE_W-1:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      rwReg   <= 1'b0;
    end else if (strobe.hitStrobe) begin
      irqFlag <= 1'b1;
      rwReg   <= shiftReg[0];
    end else if (regWr && regSel == SEL_STATUS && regWdata[0]) begin
      irqFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regSel)
      SEL_OWN:    regRdata = {ownAddr, gcEnable};
      SEL_MASK:   regRdata = {maskBits, 1'b0};
      SEL_STATUS: regRdata = {{(BYTE_W-2){1'b0}}, rwReg, irqFlag};
      default:    regRdata = '0;
    endcase
  end

  assign irq   = irqFlag;
  assign rwBit = rwReg;
endmodule

// File: rtl/i2c_addr_match_ctl.sv
module i2c_addr_match_ctl
  import i2c_addr_match_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic       addrHit,
  output ctlStrobe_t strobe,
  output logic       sdaPullLow
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  ctlState_t state, stateNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    bitCntNext = bitCnt;
    if (evt.startSeen) begin
      strobe.clrShift = 1'b1;
      stateNext       = ST_ADDR;
      bitCntNext      = '0;
    end else if (evt.stopSeen) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (evt.sclRise && bitCnt != LAST_BIT) begin
            strobe.shiftEn = 1'b1;
            bitCntNext     = bitCnt + 1'b1;
          end else if (evt.sclFall && bitCnt == LAST_BIT) begin
            if (addrHit) begin
              strobe.hitStrobe = 1'b1;
              stateNext        = ST_ACK;
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (evt.sclRise) bitCntNext = ACK_BIT;
          else if (evt.sclFall && bitCnt == ACK_BIT) stateNext = ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

  assign sdaPullLow = (state == ST_ACK);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_match_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] OWN_RESET = 8'hFE
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] regSel,
  input  logic       regWr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       sdaPullLow,
  output logic       irq,
  output logic       rwBit
);
  ctlStrobe_t strobe;
  busEvt_t    evt;
  logic       addrHit;

  i2c_addr_match_dp #(.SYNC_STAGES(SYNC_STAGES), .OWN_RESET(OWN_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .regSel(regSel), .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .evt(evt), .addrHit(addrHit), .irq(irq), .rwBit(rwBit)
  );

  i2c_addr_match_ctl u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .addrHit(addrHit),
    .strobe(strobe), .sdaPullLow(sdaPullLow)
  );
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regSel,
  input logic       regWr,
  input logic [7:0] regWdata,
  input logic [7:0] regRdata,
  input logic       sdaPullLow,
  input logic       irq,
  input logic       rwBit
);
  // R2: the mask register never shows a 1 in its lowest bit
  p_mask_lsb_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd1) |-> !regRdata[0]);

  // R7: the start of an acknowledge coincides with the flag being set
  p_ack_sets_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> irq);

  // R7: the flag stays set unless software writes 1 to clear it
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(regWr && regSel == 2'd2 && regWdata[0])) |=> irq);

  // R8: the direction output changes only when an acknowledge begins
  p_rw_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(sdaPullLow) |-> $stable(rwBit));

  // R7: the flag never rises without an acknowledge starting
  p_irq_needs_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $rose(sdaPullLow));
endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
  .regWdata(regWdata), .regRdata(regRdata), .sdaPullLow(sdaPullLow),
  .irq(irq), .rwBit(rwBit)
);

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic [1:0] regSel = 2'd0;
  logic regWr = 1'b0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic sdaPullLow, irq, rwBit;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_match u_i2c_addr_match (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .regSel(regSel), .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .sdaPullLow(sdaPullLow), .irq(irq), .rwBit(rwBit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    regSel = sel; regWdata = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [7:0] data);
    @(negedge clk);
    regSel = sel;
    #1 data = regRdata;
  endtask

  task automatic busStart();
    sdaIn = 1'b1; idle(HOLD);
    sclIn = 1'b1; idle(HOLD);
    sdaIn = 1'b0; idle(HOLD);
    sclIn = 1'b0; idle(HOLD);
  endtask

  task automatic busStop();
    sdaIn = 1'b0; idle(HOLD);
    sclIn = 1'b1; idle(HOLD);
    sdaIn = 1'b1; idle(HOLD);
  endtask

  task automatic busBit(input logic b);
    sdaIn = b;    idle(HOLD);
    sclIn = 1'b1; idle(HOLD);
    sclIn = 1'b0; idle(HOLD);
  endtask

  // Eight bits MSB first, then the acknowledge clock with SDA released.
  task automatic sendByte(input logic [7:0] b, input logic expAck, input string req);
    for (int i = 7; i >= 0; i--) busBit(b[i]);
    chk({req, " ack after 8th fall"}, sdaPullLow, expAck);
    sdaIn = 1'b1; idle(HOLD);
    sclIn = 1'b1; idle(HOLD);
    chk({req, " ack during 9th high"}, sdaPullLow, expAck);
    sclIn = 1'b0; idle(HOLD);
    chk({req, " ack released after 9th fall"}, sdaPullLow, 0);
  endtask

  function automatic logic expHit(input logic [6:0] a, input logic [6:0] own,
                                  input logic [6:0] mask, input logic gce);
    logic hit = 1'b1;
    for (int k = 0; k < 7; k++)
      if (!mask[k] && a[k] != own[k]) hit = 1'b0;
    if (gce && a == 7'd0) hit = 1'b1;
    return hit;
  endfunction

  task automatic sweep(input logic [6:0] own, input logic gce, input logic [6:0] mask,
                       input string req);
    regWrite(2'd0, {own, gce});
    regWrite(2'd1, {mask, 1'b0});
    for (int a = 0; a < 128; a++) begin
      logic hit;
      logic rw;
      hit = expHit(7'(a), own, mask, gce);
      rw = ^7'(a);
      busStart();
      sendByte({7'(a), rw}, hit, req);
      busStop();
      chk({req, " irq after address"}, irq, hit);
      if (hit) begin
        chk("R8 rwBit latched", rwBit, rw);
        regWrite(2'd2, 8'h01);
        idle(1);
        chk("R7 irq cleared by write 1", irq, 0);
      end
    end
  endtask

  initial begin
    logic [7:0] rd;
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    regRead(2'd0, rd); chk("R1 own reset", rd, 8'hFE);
    regRead(2'd1, rd); chk("R1 mask reset", rd, 8'h00);
    regRead(2'd2, rd); chk("R1 status reset", rd, 8'h00);
    chk("R1 sdaPullLow reset", sdaPullLow, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 rwBit reset", rwBit, 0);

    // R2 mask bit 0 read-only
    regWrite(2'd1, 8'hFF);
    regRead(2'd1, rd); chk("R2 mask lsb ignored", rd, 8'hFE);
    regWrite(2'd1, 8'h01);
    regRead(2'd1, rd); chk("R2 mask lsb only write", rd, 8'h00);

    // R3 plain compare, R5 general call disabled
    sweep(7'h5A, 1'b0, 7'h00, "R3 plain");
    // R4 masked compare, R5 general call enabled
    sweep(7'h21, 1'b1, 7'h0C, "R4 R5 masked+gc");
    // R3 reset address value
    sweep(7'h7F, 1'b0, 7'h00, "R3 default addr");

    // R7 write 0 keeps flag, R8 status bit 1
    regWrite(2'd0, {7'h5A, 1'b0});
    busStart(); sendByte({7'h5A, 1'b1}, 1'b1, "R6 match"); busStop();
    regWrite(2'd2, 8'h00);
    idle(1);
    chk("R7 write 0 keeps irq", irq, 1);
    regRead(2'd2, rd); chk("R8 status shows rw and irq", rd, 8'h03);
    regWrite(2'd2, 8'h01);

    // R10 repeated start in mid-address restarts capture
    busStart();
    busBit(1'b0); busBit(1'b1); busBit(1'b1); busBit(1'b0);
    busStart();
    sendByte({7'h5A, 1'b0}, 1'b1, "R10 repeated start");
    busStop();
    chk("R10 irq after repeated start", irq, 1);
    chk("R10 rw from restarted byte", rwBit, 0);
    regWrite(2'd2, 8'h01);

    // R10 bits after STOP without START are ignored
    busStart();
    busBit(1'b1); busBit(1'b0); busBit(1'b1);
    busStop();
    sclIn = 1'b0; idle(HOLD);
    sendByte({7'h5A, 1'b0}, 1'b0, "R10 after stop");
    busStop();
    chk("R10 irq stays clear after stop", irq, 0);

    // R9 mismatching address then data byte carrying own address
    busStart();
    sendByte({7'h11, 1'b0}, 1'b0, "R9 miss");
    sendByte({7'h5A, 1'b0}, 1'b0, "R9 later byte ignored");
    busStop();
    chk("R9 irq clear after miss", irq, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule